// File: doc/BRIEF.md
# Split-Aware Round-Robin Bus Arbiter

This block decides which of three bus masters owns the shared address bus. Requesters take turns in a rotating order. When nobody eligible is asking, ownership falls back to a default master, index 0, which only drives idle transfers. A new owner is chosen only on a cycle where the bus is ready. This lets the next owner's address phase overlap the data phase of the current transfer.

Slaves can refuse a transfer in two ways. A *retry* answer keeps the master eligible. A *split* answer parks the master: the arbiter records which master owned the refused data phase and sets that master's mask bit. A masked master is skipped by arbitration until the slave pulses that master's bit on the release vector. Releases carry no acknowledgement, so every pulse is applied in the cycle it appears, whatever response is on the bus. If a release and the split that would mask the same master arrive together, the release wins.

Top module: `split_rr_arbiter`

## Requirements
- R1: After reset, all mask bits are clear, the owner is the default master (owner 0, grant bit 0 set), and the first arbitration with every master requesting picks master 1.
- R2: On each ready cycle, the owner becomes the first eligible requester after the previous winner, in rotating order 1, 2, 3, 1. Exactly one grant bit is set, and grant bit k means master k owns the bus.
- R3: When no unmasked master requests on a ready cycle, the owner becomes the default master 0.
- R4: The owner never changes on a cycle where the ready input is low.
- R5: A split response (response code 2'b11) seen with ready low sets the mask bit of the data-phase owner. Bit k of the mask and of the request vector stand for master k+1. A masked master is never granted, and rotation skips it.
- R6: A release pulse on bit k clears mask bit k at the next edge. The master becomes eligible from the following arbitration.
- R7: A release pulse clears the mask even while a retry response (code 2'b10) is on the bus.
- R8: A release and a split that targets the same master in the same cycle leave that master's mask bit clear.
- R9: A retry response masks nothing. After a retry, rotation continues, so other requesters are served before the retried master owns the bus again.
- R10: A split response does not mask anything when the data phase was not a real transfer, that is, when the transfer type sampled with it was idle (2'b00) or busy (2'b01). Transfer types 2'b10 and 2'b11 carry data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NM | Bus requests, bit k from master k+1 |
| ready_i | input | 1 | Bus ready; high ends the current data phase |
| resp_i | input | 2 | Slave response: 00 okay, 01 error, 10 retry, 11 split |
| trans_i | input | 2 | Transfer type of the current address phase |
| release_i | input | NM | Split release pulses, bit k frees master k+1 |
| grant_o | output | NM+1 | One-hot grant, bit 0 is the default master |
| owner_o | output | IW | Encoded bus owner |
| mask_o | output | NM | Split mask, bit k for master k+1 |

## Verification
The directed tests target the cases where arbitration and masking interact. A release during a retry has to take effect; a design that gated release by the response would keep the master masked forever. A release that coincides with the split it cancels has to win; the wrong priority leaves a stale mask bit. Other tests check that rotation skips a masked master instead of stalling on it, that ownership is frozen while ready is low, and that a split answering an idle data phase, or the default master's data phase, sets no mask bit.

// File: rtl/sarb_pkg.sv
package sarb_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        TRN_IDLE   = 2'b00,
        TRN_BUSY   = 2'b01,
        TRN_NONSEQ = 2'b10,
        TRN_SEQ    = 2'b11
    } trn_e;

endpackage

// File: rtl/sarb_rr_pick.sv
module sarb_rr_pick #(
    parameter int NM = 3,
    parameter int IW = 2
) (
    input  logic [NM-1:0] elig_i,
    input  logic [IW-1:0] ptr_i,
    output logic          win_vld_o,
    output logic [IW-1:0] win_o
);

    // Search starts at master ptr_i (1-based) and wraps.
    always_comb begin
        win_vld_o = 1'b0;
        win_o     = '0;
        for (int off = 0; off < NM; off++) begin
            int slot;
            slot = (int'(ptr_i) + NM - 1 + off) % NM;
            if (!win_vld_o && elig_i[slot]) begin
                win_vld_o = 1'b1;
                win_o     = IW'(slot + 1);
            end
        end
    end

endmodule

// File: rtl/sarb_split_mask.sv
module sarb_split_mask #(
    parameter int NM = 3,
    parameter int IW = 2
) (
    input  logic [NM-1:0] mask_q_i,
    input  logic          split_hit_i,
    input  logic [IW-1:0] split_idx_i,
    input  logic [NM-1:0] release_i,
    output logic [NM-1:0] mask_d_o
);

    for (genvar k = 0; k < NM; k++) begin : g_bit
        logic set_k;
        assign set_k = split_hit_i && (split_idx_i == IW'(k + 1));
        // release has priority over a same-cycle set
        assign mask_d_o[k] = (mask_q_i[k] | set_k) & ~release_i[k];
    end

endmodule

// File: rtl/split_rr_arbiter.sv
module split_rr_arbiter
    import sarb_pkg::*;
#(
    parameter int NM = 3,
    localparam int IW = $clog2(NM + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NM-1:0] req_i,
    input  logic          ready_i,
    input  logic [1:0]    resp_i,
    input  logic [1:0]    trans_i,
    input  logic [NM-1:0] release_i,
    output logic [NM:0]   grant_o,
    output logic [IW-1:0] owner_o,
    output logic [NM-1:0] mask_o
);

    typedef struct packed {
        logic [IW-1:0] owner;
        logic [IW-1:0] downer;
        logic          dvalid;
        logic [NM-1:0] mask;
        logic [IW-1:0] ptr;
    } state_t;

    state_t        st_d, st_q;
    logic [NM-1:0] elig;
    logic          win_vld;
    logic [IW-1:0] win;
    logic          split_hit;
    logic [NM-1:0] mask_nxt;
    logic          xfer_phase;

    assign elig       = req_i & ~st_q.mask;
    assign xfer_phase = (trn_e'(trans_i) == TRN_NONSEQ) || (trn_e'(trans_i) == TRN_SEQ);
    assign split_hit  = !ready_i && (rsp_e'(resp_i) == RSP_SPLIT)
                        && st_q.dvalid && (st_q.downer != '0);

    sarb_rr_pick #(.NM(NM), .IW(IW)) i_pick (
        .elig_i    (elig),
        .ptr_i     (st_q.ptr),
        .win_vld_o (win_vld),
        .win_o     (win)
    );

    sarb_split_mask #(.NM(NM), .IW(IW)) i_mask (
        .mask_q_i    (st_q.mask),
        .split_hit_i (split_hit),
        .split_idx_i (st_q.downer),
        .release_i   (release_i),
        .mask_d_o    (mask_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mask = mask_nxt;
        if (ready_i) begin
            st_d.downer = st_q.owner;
            st_d.dvalid = xfer_phase;
            if (win_vld) begin
                st_d.owner = win;
                st_d.ptr   = (win == IW'(NM)) ? IW'(1) : win + IW'(1);
            end else begin
                st_d.owner = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.owner  <= '0;
            st_q.downer <= '0;
            st_q.dvalid <= 1'b0;
            st_q.mask   <= '0;
            st_q.ptr    <= IW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 0; k <= NM; k++) begin : g_grant
        assign grant_o[k] = (st_q.owner == IW'(k));
    end

    assign owner_o = st_q.owner;
    assign mask_o  = st_q.mask;

endmodule

// File: rtl/split_rr_arbiter_sva.sv
module split_rr_arbiter_sva
    import sarb_pkg::*;
#(
    parameter int NM = 3,
    parameter int IW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [NM-1:0] req_i,
    input logic          ready_i,
    input logic [1:0]    resp_i,
    input logic [NM-1:0] release_i,
    input logic [NM:0]   grant_o,
    input logic [IW-1:0] owner_o,
    input logic [NM-1:0] mask_o
);

    p_grant_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(grant_o) == 1);

    p_owner_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_i |=> $stable(owner_o));

    p_default_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && ((req_i & ~mask_o) == '0)) |=> (owner_o == '0));

    p_no_mask_without_split_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_e'(resp_i) != RSP_SPLIT) |=> ((mask_o & ~$past(mask_o)) == '0));

    for (genvar k = 0; k < NM; k++) begin : g_per
        p_masked_skipped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ready_i && mask_o[k] && owner_o != IW'(k + 1)) |=> (owner_o != IW'(k + 1)));

        p_release_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            release_i[k] |=> !mask_o[k]);
    end

endmodule

bind split_rr_arbiter split_rr_arbiter_sva #(.NM(NM), .IW(IW)) i_sva (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_i   (ready_i),
    .resp_i    (resp_i),
    .release_i (release_i),
    .grant_o   (grant_o),
    .owner_o   (owner_o),
    .mask_o    (mask_o)
);

// File: tb/test_split_rr_arbiter.sv
module test_split_rr_arbiter;

    localparam int NM = 3;
    localparam int IW = 2;

    logic          clk_i = 1'b0;
    logic          rst_ni;
    logic [NM-1:0] req_i;
    logic          ready_i;
    logic [1:0]    resp_i;
    logic [1:0]    trans_i;
    logic [NM-1:0] release_i;
    logic [NM:0]   grant_o;
    logic [IW-1:0] owner_o;
    logic [NM-1:0] mask_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk_i = ~clk_i;

    split_rr_arbiter #(.NM(NM)) i_split_rr_arbiter (
        .clk_i, .rst_ni, .req_i, .ready_i, .resp_i, .trans_i,
        .release_i, .grant_o, .owner_o, .mask_o
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_owner(input string tag, input int exp);
        chk({tag, " owner"}, int'(owner_o), exp);
        chk({tag, " grant"}, int'(grant_o), 1 << exp);
    endtask

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic do_reset();
        rst_ni    = 1'b0;
        req_i     = '0;
        ready_i   = 1'b1;
        resp_i    = 2'b00;
        trans_i   = 2'b10;
        release_i = '0;
        repeat (2) @(posedge clk_i);
        #1;
        rst_ni = 1'b1;
    endtask

    // master 1 ends up masked, owner 0
    task automatic park_master1();
        req_i = 3'b001; trans_i = 2'b10; ready_i = 1'b1; resp_i = 2'b00;
        step(); step();
        ready_i = 1'b0; resp_i = 2'b11;
        step();
        chk("R5 mask set", int'(mask_o), 1);
        chk("R4 owner held in split", int'(owner_o), 1);
        ready_i = 1'b1;
        step();
        chk_owner("R5 masked master dropped", 0);
        resp_i = 2'b00;
    endtask

    task automatic t_reset();
        do_reset();
        chk_owner("R1 reset", 0);
        chk("R1 reset mask", int'(mask_o), 0);
        req_i = 3'b111; step();
        chk_owner("R1 first pick", 1);
    endtask

    task automatic t_rotate();
        do_reset();
        req_i = 3'b111;
        step(); chk_owner("R2 turn a", 1);
        step(); chk_owner("R2 turn b", 2);
        step(); chk_owner("R2 turn c", 3);
        step(); chk_owner("R2 wrap", 1);
    endtask

    task automatic t_default();
        do_reset();
        step(); chk_owner("R3 none", 0);
        req_i = 3'b110; step(); chk_owner("R3 m2", 2);
        req_i = 3'b000; step(); chk_owner("R3 back default", 0);
    endtask

    task automatic t_hold();
        do_reset();
        req_i = 3'b111; step(); chk_owner("R4 start", 1);
        ready_i = 1'b0; req_i = 3'b100;
        step(); chk_owner("R4 held a", 1);
        step(); chk_owner("R4 held b", 1);
        ready_i = 1'b1; step(); chk_owner("R4 moves", 3);
    endtask

    task automatic t_split_release();
        do_reset();
        park_master1();
        step(); step();
        chk_owner("R5 stays out", 0);
        chk("R5 mask kept", int'(mask_o), 1);
        release_i = 3'b001; step();
        chk("R6 mask cleared", int'(mask_o), 0);
        release_i = 3'b000; step();
        chk_owner("R6 eligible again", 1);
    endtask

    task automatic t_skip_masked();
        do_reset();
        req_i = 3'b010; step(); step();
        chk_owner("R5 m2 owns", 2);
        ready_i = 1'b0; resp_i = 2'b11; step();
        chk("R5 m2 masked", int'(mask_o), 2);
        req_i = 3'b111; ready_i = 1'b1; step();
        chk_owner("R5 skip a", 3);
        resp_i = 2'b00;
        step(); chk_owner("R5 skip b", 1);
        step(); chk_owner("R5 skip c", 3);
    endtask

    task automatic t_release_in_retry();
        do_reset();
        park_master1();
        ready_i = 1'b0; resp_i = 2'b10; release_i = 3'b001;
        step();
        chk("R7 release during retry", int'(mask_o), 0);
        release_i = 3'b000; ready_i = 1'b1;
        step();
        chk_owner("R7 regrant", 1);
    endtask

    task automatic t_release_beats_split();
        do_reset();
        req_i = 3'b001; step(); step();
        ready_i = 1'b0; resp_i = 2'b11; release_i = 3'b001;
        step();
        chk("R8 release wins", int'(mask_o), 0);
        release_i = 3'b000;
    endtask

    task automatic t_retry();
        do_reset();
        req_i = 3'b111;
        step(); step(); chk_owner("R9 pre", 2);
        ready_i = 1'b0; resp_i = 2'b10; step();
        chk_owner("R9 retry cycle 1", 2);
        chk("R9 no mask", int'(mask_o), 0);
        ready_i = 1'b1; step();
        chk_owner("R9 retry cycle 2", 3);
        resp_i = 2'b00; step();
        chk_owner("R9 retried back", 1);
        chk("R9 mask still clear", int'(mask_o), 0);
    endtask

    task automatic t_idle_phase();
        do_reset();
        req_i = 3'b001; step();
        trans_i = 2'b00; step();
        ready_i = 1'b0; resp_i = 2'b11; step();
        chk("R10 idle phase", int'(mask_o), 0);
        do_reset();
        trans_i = 2'b01; req_i = 3'b001; step(); step();
        ready_i = 1'b0; resp_i = 2'b11; step();
        chk("R10 busy phase", int'(mask_o), 0);
        do_reset();
        step(); step();
        ready_i = 1'b0; resp_i = 2'b11; step();
        chk("R10 default master", int'(mask_o), 0);
    endtask

    initial begin
        #(20 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_rotate();
        t_default();
        t_hold();
        t_split_release();
        t_skip_masked();
        t_release_in_retry();
        t_release_beats_split();
        t_retry();
        t_idle_phase();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule